// File: doc/BRIEF.md
# Framebuffer Scanout Read Request Generator

This block produces the stream of burst read requests that a display pipeline needs to fetch one frame after another from memory. Software supplies a frame start address, the number of bytes to fetch on each line, the byte distance between the starts of consecutive lines, and the number of visible lines minus one. A single run bit starts the scan and stops it. The bytes of each line are cut into full bursts of a fixed number of beats, and a shorter burst fetches whatever remains at the end of the line. When a line is done, the line start moves forward by the stride. After the last line the scan returns to the frame start address.

Requests leave on a plain valid/ready handshake. The memory side returns one completion pulse per finished burst, and the block holds back new requests while the number of accepted but unfinished bursts sits at its limit. The configuration is captured when a frame begins, so a change made in the middle of a frame applies from the next frame on. When the run bit is cleared, the block still delivers a request it has already raised. It then waits until every accepted burst has completed and goes idle.

Top module: `scan_fetch_gen`

## Requirements
- R1: After reset `req_valid` and `busy` are 0.
- R2: When `cmd_run` is 1 while the block is idle, the block captures the configuration, and the first request of the frame carries address `cfg_base`.
- R3: Each line is split into bursts of `BURST_BEATS` (16) beats of `BEAT_BYTES` (8) bytes. The bursts start at line offsets 0, 128, 256 and so on. The last burst carries the remaining beats (1 to 16), and only that burst has `req_eol`=1. The value of `req_beats` is the beat count itself. `cfg_line_bytes` must be a nonzero multiple of 8.
- R4: The start address of each following line equals the start of the previous line plus `cfg_pitch`. The stride does not depend on the line length.
- R5: A frame holds `cfg_lines_m1`+1 lines. `req_eof`=1 is set only on the last burst of the last line, and the request after it starts again at the frame start address.
- R6: A change to `cfg_base`, `cfg_line_bytes`, `cfg_pitch` or `cfg_lines_m1` during a frame has no effect on that frame. The new values apply from the next frame on.
- R7: A raised request keeps its address, beat count and flags unchanged until `req_ready` accepts it.
- R8: The number of accepted bursts without a `rsp_done` pulse never exceeds `MAX_OUT` (4). No request is raised while that number is at the limit.
- R9: After `cmd_run` falls, the block accepts at most the one request it had already raised and raises no new one. `busy` stays 1 until every accepted burst has completed, and then it falls.
- R10: A start that follows a stop begins again at line 0, at the `cfg_base` value present at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_run | input | 1 | 1 runs the scan, 0 stops it |
| cfg_base | input | ADDR_W | Frame start byte address |
| cfg_line_bytes | input | LEN_W | Bytes fetched per line (multiple of BEAT_BYTES) |
| cfg_pitch | input | LEN_W | Byte stride between line starts |
| cfg_lines_m1 | input | LINE_W | Visible lines minus one |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Burst start byte address |
| req_beats | output | BW | Beats in this burst (1 to BURST_BEATS) |
| req_eol | output | 1 | Last burst of a line |
| req_eof | output | 1 | Last burst of a frame |
| rsp_done | input | 1 | One accepted burst has completed |
| busy | output | 1 | Block is scanning or draining |

## Verification
The assertions assume two things about the inputs. First, `rsp_done` pulses only while at least one accepted burst is still open. Second, the configured line length is a nonzero multiple of the beat size, so every burst carries between 1 and 16 beats. The bench keeps its own count of open bursts and drives completions only while that count is positive. It uses only line lengths of 8, 128, 296 and 1024 bytes. It varies the accept stalls and the completion rates, so both the outstanding limit and the drain after a stop are reached.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } scan_state_e;
endpackage

// File: rtl/scan_credit_ctr.sv
module scan_credit_ctr #(
  parameter int MAX_OUT = 4,
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] count,
  output logic          avail
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (take && !give) count <= count + 1'b1;
    else if (give && !take) count <= count - 1'b1;
  end

  assign avail = (count < CW'(MAX_OUT));

  // R8: an acceptance never lands while the limit is already reached
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    take |-> (count < CW'(MAX_OUT)));
  // R8: completions only arrive against open bursts
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (give && !take) |-> (count != '0));
endmodule

// File: rtl/scan_burst_sizer.sv
module scan_burst_sizer #(
  parameter int LEN_W       = 16,
  parameter int BEAT_BYTES  = 8,
  parameter int BURST_BEATS = 16,
  localparam int BEAT_SH = $clog2(BEAT_BYTES),
  localparam int BW      = $clog2(BURST_BEATS + 1)
) (
  input  logic [LEN_W-1:0] line_bytes,
  input  logic [LEN_W-1:0] offset,
  output logic [BW-1:0]    beats,
  output logic             last
);
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] remain_beats;

  always_comb begin
    remain       = line_bytes - offset;
    remain_beats = remain >> BEAT_SH;
    if (remain_beats >= LEN_W'(BURST_BEATS)) begin
      beats = BW'(BURST_BEATS);
      last  = (remain_beats == LEN_W'(BURST_BEATS));
    end else begin
      beats = BW'(remain_beats);
      last  = 1'b1;
    end
  end
endmodule

// File: rtl/scan_line_walker.sv
module scan_line_walker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [LEN_W-1:0]  pitch_in,
  output logic [ADDR_W-1:0] line_start,
  output logic [LINE_W-1:0] line_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_start <= '0;
      line_idx   <= '0;
    end else if (load) begin
      line_start <= base_in;
      line_idx   <= '0;
    end else if (step) begin
      line_start <= line_start + ADDR_W'(pitch_in);
      line_idx   <= line_idx + 1'b1;
    end
  end

  // R4: each new line start is the previous one plus the stride
  assert_line_stride_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (line_start == $past(line_start) + ADDR_W'($past(pitch_in))));
  // R5: a frame load restarts the line index
  assert_frame_reload_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (line_idx == '0 && line_start == $past(base_in)));
endmodule

// File: rtl/scan_fetch_gen.sv
module scan_fetch_gen
  import scan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int LINE_W      = 12,
  parameter int BEAT_BYTES  = 8,
  parameter int BURST_BEATS = 16,
  parameter int MAX_OUT     = 4,
  localparam int BW          = $clog2(BURST_BEATS + 1),
  localparam int CW          = $clog2(MAX_OUT + 1),
  localparam int BURST_BYTES = BEAT_BYTES * BURST_BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_run,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_line_bytes,
  input  logic [LEN_W-1:0]  cfg_pitch,
  input  logic [LINE_W-1:0] cfg_lines_m1,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BW-1:0]     req_beats,
  output logic              req_eol,
  output logic              req_eof,
  input  logic              rsp_done,
  output logic              busy
);
  scan_state_e       state;
  logic [LEN_W-1:0]  len_l;
  logic [LEN_W-1:0]  pitch_l;
  logic [LINE_W-1:0] lines_l;
  logic [LEN_W-1:0]  offset;
  logic [ADDR_W-1:0] line_start;
  logic [LINE_W-1:0] line_idx;
  logic [BW-1:0]     next_beats;
  logic              next_last;
  logic [CW-1:0]     out_cnt;
  logic              credit_ok;
  logic              accept;
  logic              frame_begin;
  logic              frame_wrap;

  assign accept      = req_valid && req_ready;
  assign frame_begin = (state == ST_IDLE) && cmd_run;
  assign frame_wrap  = accept && req_eof;
  assign busy        = (state != ST_IDLE);

  scan_line_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_W(LINE_W)
  ) u_walker (
    .clk       (clk),
    .rst       (rst),
    .load      (frame_begin || frame_wrap),
    .step      (accept && req_eol && !req_eof),
    .base_in   (cfg_base),
    .pitch_in  (pitch_l),
    .line_start(line_start),
    .line_idx  (line_idx)
  );

  scan_burst_sizer #(
    .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .BURST_BEATS(BURST_BEATS)
  ) u_sizer (
    .line_bytes(len_l),
    .offset    (offset),
    .beats     (next_beats),
    .last      (next_last)
  );

  scan_credit_ctr #(
    .MAX_OUT(MAX_OUT)
  ) u_credit (
    .clk  (clk),
    .rst  (rst),
    .take (accept),
    .give (rsp_done),
    .count(out_cnt),
    .avail(credit_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_beats <= '0;
      req_eol   <= 1'b0;
      req_eof   <= 1'b0;
      offset    <= '0;
      len_l     <= '0;
      pitch_l   <= '0;
      lines_l   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_run) begin
            state   <= ST_ISSUE;
            offset  <= '0;
            len_l   <= cfg_line_bytes;
            pitch_l <= cfg_pitch;
            lines_l <= cfg_lines_m1;
          end
        end
        ST_ISSUE: begin
          if (req_valid) begin
            if (req_ready) begin
              req_valid <= 1'b0;
              if (req_eol) offset <= '0;
              else         offset <= offset + LEN_W'(BURST_BYTES);
              if (req_eof) begin
                len_l   <= cfg_line_bytes;
                pitch_l <= cfg_pitch;
                lines_l <= cfg_lines_m1;
              end
              if (!cmd_run) state <= ST_DRAIN;
            end
          end else if (!cmd_run) begin
            state <= ST_DRAIN;
          end else if (credit_ok) begin
            req_valid <= 1'b1;
            req_addr  <= line_start + ADDR_W'(offset);
            req_beats <= next_beats;
            req_eol   <= next_last;
            req_eof   <= next_last && (line_idx == lines_l);
          end
        end
        ST_DRAIN: begin
          if (out_cnt == '0) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a waiting request does not move
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_beats) && $stable(req_eol) && $stable(req_eof)));
  // R9: a new request is only raised while running
  assert_raise_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> $past(cmd_run));
  // R9: idle only once all accepted bursts have completed
  assert_idle_after_drain_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(out_cnt) == '0));
  // R9: nothing is requested while idle
  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);
  // R3: a burst carries between one and the full beat count
  assert_beat_range_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_beats != '0 && req_beats <= BW'(BURST_BEATS)));
  // R5: end of frame only on an end of line
  assert_eof_on_eol_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_eof) |-> req_eol);
endmodule

// File: tb/tb_scan_fetch_gen.sv
module tb_scan_fetch_gen;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int LINE_W = 12;
  localparam int MAX_OUT = 4;
  localparam int BW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst;
  logic              cmd_run;
  logic [ADDR_W-1:0] cfg_base;
  logic [LEN_W-1:0]  cfg_line_bytes;
  logic [LEN_W-1:0]  cfg_pitch;
  logic [LINE_W-1:0] cfg_lines_m1;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [BW-1:0]     req_beats;
  logic              req_eol;
  logic              req_eof;
  logic              rsp_done;
  logic              busy;

  scan_fetch_gen dut (
    .clk(clk), .rst(rst), .cmd_run(cmd_run), .cfg_base(cfg_base),
    .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch),
    .cfg_lines_m1(cfg_lines_m1), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .req_eol(req_eol),
    .req_eof(req_eof), .rsp_done(rsp_done), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ready_mode = 1;
  int done_period = 5;
  int bo = 0;
  int acc_total = 0;
  int eof_total = 0;
  bit hit_limit = 0;
  logic [31:0] m_base;
  int m_len, m_pitch, m_lm1, m_off, m_idx;
  bit cap_req = 0;
  logic [31:0] cap_addr;
  logic [31:0] frame_first [8];
  bit pv_hold = 0;
  logic [31:0] pv_addr;
  logic [BW-1:0] pv_beats;
  logic pv_eol, pv_eof;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Drives ready and completions, samples and models every accepted request
  initial begin
    req_ready = 1'b0;
    rsp_done  = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      req_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      rsp_done  = (bo > 0) && ((cyc % done_period) == 0);
      #1;
      if (!rst) begin
        if (pv_hold) begin
          chk(req_valid && req_addr == pv_addr && req_beats == pv_beats &&
              req_eol == pv_eol && req_eof == pv_eof, "R7 held request changed",
              longint'(req_addr), longint'(pv_addr));
        end
        if (req_valid && req_ready) begin
          logic [31:0] ea;
          int rem, eb;
          bit eeol, eeof;
          ea   = m_base + 32'(m_idx * m_pitch) + 32'(m_off);
          rem  = (m_len - m_off) / 8;
          eb   = (rem > 16) ? 16 : rem;
          eeol = (m_off + eb * 8 == m_len);
          eeof = eeol && (m_idx == m_lm1);
          chk(req_addr == ea, "R4 R6 burst address", longint'(req_addr), longint'(ea));
          chk(int'(req_beats) == eb, "R3 burst beats", longint'(req_beats), longint'(eb));
          chk(req_eol == eeol, "R3 end-of-line flag", longint'(req_eol), longint'(eeol));
          chk(req_eof == eeof, "R5 end-of-frame flag", longint'(req_eof), longint'(eeof));
          chk(bo < MAX_OUT, "R8 outstanding at accept", longint'(bo), longint'(MAX_OUT - 1));
          if (cap_req) begin cap_addr = req_addr; cap_req = 0; end
          if (m_off == 0 && m_idx == 0) frame_first[eof_total % 8] = req_addr;
          acc_total++;
          if (eeol) begin
            m_off = 0;
            if (eeof) begin
              m_base = cfg_base; m_len = int'(cfg_line_bytes);
              m_pitch = int'(cfg_pitch); m_lm1 = int'(cfg_lines_m1);
              m_idx = 0;
              eof_total++;
            end else m_idx++;
          end else m_off += 128;
        end
        bo = bo + ((req_valid && req_ready) ? 1 : 0) - (rsp_done ? 1 : 0);
        if (bo == MAX_OUT) hit_limit = 1;
        pv_hold  = req_valid && !req_ready;
        pv_addr  = req_addr; pv_beats = req_beats;
        pv_eol   = req_eol;  pv_eof   = req_eof;
      end
    end
  end

  task automatic start_scan(input logic [31:0] b, input int len, input int p, input int lm1);
    @(negedge clk);
    cfg_base = b; cfg_line_bytes = LEN_W'(len); cfg_pitch = LEN_W'(p);
    cfg_lines_m1 = LINE_W'(lm1);
    m_base = b; m_len = len; m_pitch = p; m_lm1 = lm1; m_off = 0; m_idx = 0;
    cap_req = 1;
    cmd_run = 1'b1;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = eof_total + n;
    while (eof_total < target) @(negedge clk);
  endtask

  task automatic stop_scan();
    bit pend;
    int snap;
    @(negedge clk);
    cmd_run = 1'b0;
    pend = req_valid;
    snap = acc_total;
    @(negedge clk);
    while (busy) @(negedge clk);
    chk(bo == 0, "R9 open bursts when idle", longint'(bo), 0);
    chk(acc_total - snap == int'(pend), "R9 accepts after stop",
        longint'(acc_total - snap), longint'(pend));
    chk(!req_valid, "R9 request while idle", longint'(req_valid), 0);
  endtask

  initial begin
    rst = 1'b1; cmd_run = 1'b0;
    cfg_base = '0; cfg_line_bytes = '0; cfg_pitch = '0; cfg_lines_m1 = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_valid, "R1 valid after reset", longint'(req_valid), 0);
    chk(!busy, "R1 busy after reset", longint'(busy), 0);

    // 296-byte lines: bursts of 16,16,5 beats; base change mid-frame
    ready_mode = 1; done_period = 5;
    start_scan(32'h1000, 296, 320, 2);
    while (acc_total < 2) @(negedge clk);
    chk(cap_addr == 32'h1000, "R2 first address", longint'(cap_addr), 32'h1000);
    cfg_base = 32'h8000;
    wait_frames(2);
    chk(frame_first[0] == 32'h1000, "R6 old frame keeps old base",
        longint'(frame_first[0]), 32'h1000);
    chk(frame_first[1] == 32'h8000, "R6 next frame uses new base",
        longint'(frame_first[1]), 32'h8000);
    chk(hit_limit, "R8 limit reached under slow completions", longint'(hit_limit), 1);
    while (m_idx != 1) @(negedge clk);
    stop_scan();

    // restart after a mid-frame stop
    start_scan(32'h2000, 296, 320, 2);
    begin
      int a0;
      a0 = acc_total;
      while (acc_total == a0) @(negedge clk);
    end
    chk(cap_addr == 32'h2000, "R10 restart address", longint'(cap_addr), 32'h2000);
    wait_frames(1);
    stop_scan();

    // one full burst per line, one line per frame
    ready_mode = 0; done_period = 1;
    start_scan(32'h4000, 128, 128, 0);
    wait_frames(3);
    stop_scan();

    // single-beat lines with a large stride
    ready_mode = 1; done_period = 3;
    start_scan(32'h10000, 8, 4096, 3);
    wait_frames(2);
    stop_scan();

    // eight full bursts per line, stride larger than the line
    ready_mode = 0; done_period = 7;
    start_scan(32'h0, 1024, 1536, 1);
    wait_frames(2);
    stop_scan();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule